// File: doc/BRIEF.md
# MDIO Management Controller

This block is a register-mapped master for the two-wire PHY management bus. A host reaches it through a plain word-indexed register port. The host loads a target PHY address and register number. A write is launched by storing the 16-bit write value. A read is launched by raising a command bit from 0 to 1. The controller then serialises a Clause 22 frame on MDC/MDIO and reports progress through an indication word. Read results land in a data word that the host collects once the not-valid flag has dropped.

MDC is derived from the system clock by a power-of-two divider selected in the configuration word. The controller drives MDIO on the falling MDC edge and samples it on the rising edge. The data line leaves the block as a split output, output-enable and input trio, which the pad ring turns into a tri-state pin. Writing 1 to the top bit of the configuration word aborts whatever frame is running.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the configuration word (index 0) reads 7, and the command (1), address (2), write-data (3), read-data (4) and indication (5) words read 0.
- R2: The address word keeps the PHY address in bits 12:8 and the register number in bits 4:0; every other bit reads 0.
- R3: Writing word 3 while idle starts a write frame: 32 ones, start 01, opcode 01, PHY address MSB first, register number MSB first, turnaround 10, then data bits 15:0 MSB first; `mdio_oe` is high for all 64 bits.
- R4: A read starts only when a write to word 1 changes its bit 0 from 0 to 1; writing 1 when bit 0 already holds 1 starts nothing.
- R5: A read frame carries opcode 10. `mdio_oe` is low for the two turnaround bits and the 16 data bits. The bits sampled on rising MDC appear in read-data bits 15:0, MSB first.
- R6: Indication bit 0 (busy) reads 1 from the cycle after a frame is started until the frame's last bit has completed.
- R7: Indication bit 2 (not-valid) is set together with busy when a read starts. It clears in the same cycle the read data is stored, and it is never 1 while busy is 0.
- R8: Writes to word 1 or word 3 while busy is 1 are ignored: the stored values do not change and no extra frame is sent.
- R9: Writing word 0 with bit 31 set aborts any frame and clears busy and not-valid. Within two cycles MDC and `mdio_oe` are low. Bit 31 always reads 0.
- R10: Configuration bits 2:0 (sel) set each MDC half period to 2^(sel+1) system clock cycles.
- R11: While no frame is running, MDC is held low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 3 | Register word index |
| host_we | input | 1 | Register write strobe |
| host_wdata | input | 32 | Register write value |
| host_rdata | output | 32 | Register read value (combinational on host_sel) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A PHY model in the bench rebuilds every frame from the rising MDC edges and compares it with frames that the stimulus tasks queue. A design that shifts the addresses, opcode or turnaround wrongly, or that drives the line during the read turnaround, fails that comparison. The bench writes word 1 a second time with 1 already stored. A controller that starts a read on level instead of edge sends an unexpected frame. The bench also writes words 1 and 3 in mid-frame, which exposes a design that loses its write value or restarts the frame. Aborts are issued in the middle of a write frame and in the middle of a read frame, and the MDC high time is measured at two divider settings. These catch a stuck not-valid flag and an off-by-one divider.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   localparam int PRE_BITS   = 32;
   localparam int ADR_W      = 5;
   localparam int DAT_W      = 16;
   localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADR_W + 2 + DAT_W;
   localparam int DRIVE_BITS = FRAME_BITS - DAT_W - 2;
   localparam int DATA_START = FRAME_BITS - DAT_W;
   localparam int PHY_LSB    = 8;
   localparam int ABORT_BIT  = 31;
   localparam int IND_BUSY   = 0;
   localparam int IND_NVALID = 2;

   typedef enum logic [2:0] {
      W_CFG   = 3'd0,
      W_CMD   = 3'd1,
      W_ADDR  = 3'd2,
      W_WDATA = 3'd3,
      W_RDATA = 3'd4,
      W_IND   = 3'd5
   } word_idx_e;

   function automatic logic [FRAME_BITS-1:0] build_frame(input logic is_rd,
                                                         input logic [ADR_W-1:0] phy,
                                                         input logic [ADR_W-1:0] rg,
                                                         input logic [DAT_W-1:0] d);
      logic [1:0] op;
      logic [1:0] ta;
      logic [DAT_W-1:0] pay;
      op  = is_rd ? 2'b10 : 2'b01;
      ta  = is_rd ? 2'b00 : 2'b10;
      pay = is_rd ? '0 : d;
      return {{PRE_BITS{1'b1}}, 2'b01, op, phy, rg, ta, pay};
   endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             mdc,
   output logic             rise_evt,
   output logic             fall_evt
);
   localparam int CNT_W = 1 << SEL_W;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("mdio_clk_gen: SEL_W must lie in 1..4");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   half_m1;
   logic [SEL_W:0]   sh_amt;
   logic             tick;

   assign sh_amt   = {1'b0, sel} + {{SEL_W{1'b0}}, 1'b1};
   assign half_m1  = ({{CNT_W{1'b0}}, 1'b1} << sh_amt) - {{CNT_W{1'b0}}, 1'b1};
   assign tick     = en && ({1'b0, cnt_q} >= half_m1);
   assign rise_evt = tick && !mdc;
   assign fall_evt = tick && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         mdc   <= ~mdc;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R10
   mdc_edge_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && mdc != $past(mdc)) |-> $past(tick));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_mgmt_pkg::*;
#(
   parameter bit SYNC_IN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic             start_wr,
   input  logic             start_rd,
   input  logic [ADR_W-1:0] phy_addr,
   input  logic [ADR_W-1:0] reg_addr,
   input  logic [DAT_W-1:0] wr_data,
   input  logic             rise_evt,
   input  logic             fall_evt,
   input  logic             mdio_i,
   output logic             busy,
   output logic             done,
   output logic [DAT_W-1:0] rd_data,
   output logic             mdio_o,
   output logic             mdio_oe
);
   localparam int IDX_W = $clog2(FRAME_BITS);
   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
   localparam logic [IDX_W-1:0] DRV_LIMIT = IDX_W'(DRIVE_BITS);
   localparam logic [IDX_W-1:0] DAT_FIRST = IDX_W'(DATA_START);

   logic [FRAME_BITS-1:0] tx_q;
   logic [IDX_W-1:0]      idx_q;
   logic                  rd_mode_q;
   logic [DAT_W-1:0]      rx_q;
   logic                  din;

   if (SYNC_IN) begin : g_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= 2'b11;
         else        sync_q <= {sync_q[0], mdio_i};
      end
      assign din = sync_q[1];
   end else begin : g_direct
      assign din = mdio_i;
   end

   assign done    = busy && fall_evt && (idx_q == LAST_IDX);
   assign rd_data = rx_q;
   assign mdio_o  = tx_q[FRAME_BITS-1];
   assign mdio_oe = busy && (!rd_mode_q || idx_q < DRV_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         rd_mode_q <= 1'b0;
         idx_q     <= '0;
         tx_q      <= '0;
         rx_q      <= '0;
      end else if (abort) begin
         busy      <= 1'b0;
         rd_mode_q <= 1'b0;
         idx_q     <= '0;
      end else if (!busy) begin
         if (start_wr || start_rd) begin
            busy      <= 1'b1;
            rd_mode_q <= start_rd;
            idx_q     <= '0;
            tx_q      <= build_frame(start_rd, phy_addr, reg_addr, wr_data);
         end
      end else begin
         if (rise_evt && rd_mode_q && idx_q >= DAT_FIRST)
            rx_q <= {rx_q[DAT_W-2:0], din};
         if (fall_evt) begin
            if (idx_q == LAST_IDX) begin
               busy <= 1'b0;
            end else begin
               idx_q <= idx_q + 1'b1;
               tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
            end
         end
      end
   end

   // R5
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_mode_q && rise_evt && idx_q >= DAT_FIRST) |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_mgmt_pkg::*;
#(
   parameter int SEL_W   = 3,
   parameter bit SYNC_IN = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  host_sel,
   input  logic        host_we,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   logic [SEL_W-1:0] sel_q;
   logic             cmd_q;
   logic [ADR_W-1:0] phy_q, reg_q;
   logic [DAT_W-1:0] wdat_q, rdat_q;
   logic             nvalid_q;
   logic             busy_w, done_w, rise_w, fall_w;
   logic [DAT_W-1:0] rx_w;
   logic             soft_rst, wr_ok, cmd_ok, start_rd;
   logic             unused_wbits;

   assign soft_rst = host_we && host_sel == W_CFG && host_wdata[ABORT_BIT];
   assign wr_ok    = host_we && host_sel == W_WDATA && !busy_w;
   assign cmd_ok   = host_we && host_sel == W_CMD && !busy_w;
   assign start_rd = cmd_ok && host_wdata[0] && !cmd_q;
   assign unused_wbits = ^{host_wdata[30:16], host_wdata[7:5]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '1;
         cmd_q    <= 1'b0;
         phy_q    <= '0;
         reg_q    <= '0;
         wdat_q   <= '0;
         rdat_q   <= '0;
         nvalid_q <= 1'b0;
      end else begin
         if (host_we && host_sel == W_CFG) sel_q <= host_wdata[SEL_W-1:0];
         if (cmd_ok) cmd_q <= host_wdata[0];
         if (host_we && host_sel == W_ADDR) begin
            phy_q <= host_wdata[PHY_LSB +: ADR_W];
            reg_q <= host_wdata[ADR_W-1:0];
         end
         if (wr_ok) wdat_q <= host_wdata[DAT_W-1:0];
         if (soft_rst) nvalid_q <= 1'b0;
         else if (start_rd) nvalid_q <= 1'b1;
         else if (done_w && nvalid_q) begin
            nvalid_q <= 1'b0;
            rdat_q   <= rx_w;
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      case (host_sel)
         W_CFG:   host_rdata[SEL_W-1:0] = sel_q;
         W_CMD:   host_rdata[0] = cmd_q;
         W_ADDR:  begin
            host_rdata[PHY_LSB +: ADR_W] = phy_q;
            host_rdata[ADR_W-1:0]        = reg_q;
         end
         W_WDATA: host_rdata[DAT_W-1:0] = wdat_q;
         W_RDATA: host_rdata[DAT_W-1:0] = rdat_q;
         W_IND:   begin
            host_rdata[IND_BUSY]   = busy_w;
            host_rdata[IND_NVALID] = nvalid_q;
         end
         default: host_rdata = '0;
      endcase
   end

   mdio_clk_gen #(.SEL_W(SEL_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .en(busy_w), .sel(sel_q),
      .mdc(mdc), .rise_evt(rise_w), .fall_evt(fall_w)
   );

   mdio_frame_engine #(.SYNC_IN(SYNC_IN)) u_eng (
      .clk(clk), .rst_n(rst_n), .abort(soft_rst),
      .start_wr(wr_ok), .start_rd(start_rd),
      .phy_addr(phy_q), .reg_addr(reg_q), .wr_data(host_wdata[DAT_W-1:0]),
      .rise_evt(rise_w), .fall_evt(fall_w), .mdio_i(mdio_i),
      .busy(busy_w), .done(done_w), .rd_data(rx_w),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   // R6
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok || start_rd) |=> busy_w);
   // R7
   nvalid_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nvalid_q |-> busy_w);
   // R9
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!busy_w && !nvalid_q && !mdio_oe));
   // R8
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_sel == W_WDATA && busy_w) |=> $stable(wdat_q));
   // R11
   idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_w && $past(!busy_w)) |-> !mdc);
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  host_sel = 3'd0;
   logic        host_we = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int errors = 0;
   int frames_seen = 0;
   int bitcnt = 0;
   logic [63:0] cap_bits, cap_oe;
   logic [63:0] exp_bits_q[$];
   logic [63:0] exp_oe_q[$];
   logic        phy_rd = 1'b0;
   logic [15:0] phy_val = '0;

   always #4 clk = ~clk;

   mdio_mgmt_ctrl dut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // PHY model and scoreboard monitor
   always @(posedge mdc) begin
      cap_bits[63-bitcnt] = mdio_o;
      cap_oe[63-bitcnt]   = mdio_oe;
      bitcnt++;
      if (bitcnt == 64) begin
         bitcnt = 0;
         frames_seen++;
         if (exp_bits_q.size() == 0) begin
            chk(1'b0, "R4/R8 unexpected frame", cap_bits, 64'h0);
         end else begin
            logic [63:0] eb, eo;
            eb = exp_bits_q.pop_front();
            eo = exp_oe_q.pop_front();
            chk(cap_oe == eo, "R3/R5 drive enable pattern", cap_oe, eo);
            chk((cap_bits & eo) == (eb & eo), "R3/R5 frame bits", cap_bits & eo, eb & eo);
         end
      end
   end

   always @(negedge mdc) begin
      if (phy_rd && bitcnt >= 48 && bitcnt < 64) mdio_i = phy_val[63-bitcnt];
      else mdio_i = 1'b1;
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      host_sel = a; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      host_sel = a;
      #1 d = host_rdata;
   endtask

   task automatic push_frame(input bit is_rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
      if (is_rd) begin
         exp_bits_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 2'b00, 16'h0});
         exp_oe_q.push_back({{46{1'b1}}, 18'h0});
      end else begin
         exp_bits_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d});
         exp_oe_q.push_back({64{1'b1}});
      end
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 40000; i++) begin
         rd(3'd5, v);
         if (v[2] && !v[0]) chk(1'b0, "R7 not-valid without busy", v, 32'h0);
         if (!v[0]) break;
      end
   endtask

   task automatic measure_high(output int n);
      n = 0;
      @(posedge mdc);
      do begin
         @(negedge clk);
         if (mdc) n++;
      end while (mdc);
   endtask

   task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] val);
      logic [31:0] v;
      wr(3'd2, {19'h0, phy, 3'h0, rg});
      phy_rd = 1'b1; phy_val = val;
      push_frame(1'b1, phy, rg, 16'h0);
      wr(3'd1, 32'h0);
      wr(3'd1, 32'h1);
      rd(3'd5, v);
      chk(v == 32'h5, "R7 busy and not-valid after read start", v, 32'h5);
      wait_idle();
      rd(3'd4, v);
      chk(v == {16'h0, val}, "R5 read data stored", v, {16'h0, val});
      rd(3'd5, v);
      chk(v == 32'h0, "R7 flags clear after read", v, 32'h0);
      phy_rd = 1'b0;
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int n, f0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int i = 0; i < 6; i++) begin
         rd(3'(i), v);
         chk(v == ((i == 0) ? 32'd7 : 32'd0), "R1 reset value", v, (i == 0) ? 32'd7 : 32'd0);
      end
      // R2 field masking
      wr(3'd2, 32'hFFFF_FFFF);
      rd(3'd2, v);
      chk(v == 32'h0000_1F1F, "R2 address fields", v, 32'h1F1F);
      wr(3'd2, 32'h0000_0A13);
      rd(3'd2, v);
      chk(v == 32'h0000_0A13, "R2 address readback", v, 32'h0A13);
      // R3 write frame, R6 busy, R8 ignored writes, R10 divider at sel 0
      wr(3'd0, 32'h0);
      push_frame(1'b0, 5'h0A, 5'h13, 16'hA5C3);
      wr(3'd3, 32'h0000_A5C3);
      rd(3'd5, v);
      chk(v == 32'h1, "R6 busy after write start", v, 32'h1);
      wr(3'd3, 32'h0000_1234);
      wr(3'd1, 32'h1);
      rd(3'd3, v);
      chk(v == 32'hA5C3, "R8 write data kept", v, 32'hA5C3);
      rd(3'd1, v);
      chk(v == 32'h0, "R8 command kept", v, 32'h0);
      rd(3'd5, v);
      chk(v == 32'h1, "R8 no read started while busy", v, 32'h1);
      measure_high(n);
      chk(n == 2, "R10 half period sel 0", 64'(n), 64'd2);
      wait_idle();
      chk(frames_seen == 1 && exp_bits_q.size() == 0, "R8 single frame", 64'(frames_seen), 64'd1);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R11 idle lines", {mdc, mdio_oe}, 2'b00);
      // R5 read frames
      do_read(5'h1F, 5'h01, 16'h5A3C);
      // R4 level does not restart
      f0 = frames_seen;
      wr(3'd1, 32'h1);
      repeat (20) @(negedge clk);
      rd(3'd5, v);
      chk(v == 32'h0, "R4 no read on held bit", v, 32'h0);
      chk(frames_seen == f0, "R4 no extra frame", 64'(frames_seen), 64'(f0));
      do_read(5'h05, 5'h1E, 16'h8001);
      // R10 divider at sel 2
      wr(3'd0, 32'h2);
      rd(3'd0, v);
      chk(v == 32'h2, "R10 divider select readback", v, 32'h2);
      wr(3'd2, 32'h0000_1100);
      push_frame(1'b0, 5'h11, 5'h00, 16'h00FF);
      wr(3'd3, 32'h0000_00FF);
      measure_high(n);
      chk(n == 8, "R10 half period sel 2", 64'(n), 64'd8);
      wait_idle();
      // R9 abort in a write frame
      wr(3'd0, 32'h0);
      wr(3'd3, 32'h0000_7777);
      repeat (100) @(negedge clk);
      wr(3'd0, 32'h8000_0000);
      @(negedge clk);
      rd(3'd5, v);
      chk(v == 32'h0, "R9 busy cleared by abort", v, 32'h0);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9 lines low after abort", {mdc, mdio_oe}, 2'b00);
      rd(3'd0, v);
      chk(v == 32'h0, "R9 abort bit reads 0", v, 32'h0);
      bitcnt = 0;
      // R9 abort in a read frame clears not-valid
      wr(3'd1, 32'h0);
      wr(3'd1, 32'h1);
      repeat (60) @(negedge clk);
      wr(3'd0, 32'h8000_0000);
      @(negedge clk);
      rd(3'd5, v);
      chk(v == 32'h0, "R9 not-valid cleared by abort", v, 32'h0);
      bitcnt = 0;
      // controller still works after abort
      push_frame(1'b0, 5'h11, 5'h00, 16'hC0DE);
      wr(3'd3, 32'h0000_C0DE);
      wait_idle();
      chk(exp_bits_q.size() == 0, "R3 frame after abort", 64'(exp_bits_q.size()), 64'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule